// File: doc/BRIEF.md
# DRAM Controller Configuration Register Bank

This block holds the software-visible setup of a DRAM controller. One bank-configuration word sets the data bus width, the CAS latency, the internal bank count, the page size and the memory's output drive strength. A parameterized set of 32-bit timing words, two by default, is stored opaquely and handed to the command logic. Registers are reached through a plain synchronous bus. A write is taken on the rising clock edge when the write enable is high. Read data is a combinational function of the address.

Two guards protect the settings. The drive-strength bit moves only through a handshake: one write sets the boot-unlock bit, and a second write clears it while carrying the new drive value. A separate timing-unlock bit in the configuration word must already be set before any timing word accepts a write. When a configuration write actually changes the drive strength, CAS latency, bank count or page size, the block emits a one-cycle start pulse that tells the initialization sequencer to bring the memory up again.

Top module: `dram_cfg_regs`

## Requirements
- R1: While reset is asserted and after it, the configuration word reads 0x0017_0A20, every timing word reads 0, init_start is 0, and the decoded outputs are drive_weak=1, bus16_sel=0, cas_lat=5, bank_code=2, page_code=0.
- R2: In the configuration word, bits 31..24, 13..12, 8..7 and 3 always read 0 and bits 17..16 always read 3. Bits 22..19 are an ordinary read/write field.
- R3: Field positions in the configuration word: boot-unlock at bit 23, drive strength at bit 18 (1 = weak, 0 = normal), timing-unlock at bit 15, bus-width select at bit 14 (1 = 16-bit, 0 = 32-bit), CAS latency at bits 11..9, bank count at bits 6..4, page size at bits 2..0. Each field is presented on its own output port.
- R4: Drive strength takes the written bit 18 only when the stored boot-unlock bit is 1 and the write has bit 23 = 0.
- R5: Every other configuration write leaves drive strength unchanged, including a write with bit 23 = 1 while boot-unlock is already set.
- R6: While the stored timing-unlock bit is 0, writes to the timing words are ignored.
- R7: While the stored timing-unlock bit is 1, the timing words accept writes. They read back their stored value whatever the lock state.
- R8: init_start is high for exactly the one cycle after a configuration write that changes the stored drive strength, CAS latency, bank count or page size.
- R9: A configuration write that changes none of those four fields, such as an unlock-only write, a blocked drive change or a repeat of the same values, produces no init_start pulse.
- R10: Reads of unmapped addresses return 0, and writes to them change nothing.
- R11: Address map in words: configuration at 0, timing word i at 1+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| init_start | output | 1 | One-cycle initialization request |
| drive_weak | output | 1 | Drive strength, 1 = weak |
| bus16_sel | output | 1 | 1 = 16-bit data bus |
| cas_lat | output | 3 | CAS latency code |
| bank_code | output | 3 | Internal bank count code |
| page_code | output | 3 | Page size code |
| tim_flat | output | NUM_TIM*32 | Timing words, word i at bits 32*i+31..32*i |

## Verification
The assertions assume that bus_addr, bus_we and bus_wdata are stable across each rising edge and free of X while reset is released. They also assume that a change of a stored field can only come from a write seen on the previous edge. The bench drives all bus inputs on the falling edge and leaves bus_we low between transactions, so each edge carries at most one well-defined write. Reset is applied and released away from the rising edge so that the internal synchronizer never sees a late release.

// File: rtl/dram_cfg_pkg.sv
package dram_cfg_pkg;
  localparam int DATA_W   = 32;
  localparam int B_BOOT   = 23;
  localparam int B_DRIVE  = 18;
  localparam int B_TUNL   = 15;
  localparam int B_BUS16  = 14;
  localparam int CL_LO    = 9;
  localparam int BANK_LO  = 4;
  localparam int PAGE_LO  = 0;
  localparam int SPARE_LO = 19;
  localparam int CODE_W   = 3;

  typedef struct packed {
    logic              boot;
    logic [3:0]        spare;
    logic              drive;
    logic              tunl;
    logic              bus16;
    logic [CODE_W-1:0] cl;
    logic [CODE_W-1:0] bank;
    logic [CODE_W-1:0] page;
  } cfg_t;

  localparam cfg_t CFG_RST = '{boot: 1'b0, spare: 4'h2, drive: 1'b1, tunl: 1'b0,
                               bus16: 1'b0, cl: 3'h5, bank: 3'h2, page: 3'h0};

  function automatic logic [DATA_W-1:0] cfg_word(cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[B_BOOT]                   = c.boot;
    w[SPARE_LO+3:SPARE_LO]      = c.spare;
    w[B_DRIVE]                  = c.drive;
    w[17:16]                    = 2'b11;
    w[B_TUNL]                   = c.tunl;
    w[B_BUS16]                  = c.bus16;
    w[CL_LO+CODE_W-1:CL_LO]     = c.cl;
    w[BANK_LO+CODE_W-1:BANK_LO] = c.bank;
    w[PAGE_LO+CODE_W-1:PAGE_LO] = c.page;
    return w;
  endfunction
endpackage

// File: rtl/dram_rst_sync.sv
module dram_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/dram_cfg_word.sv
module dram_cfg_word
  import dram_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output cfg_t              cfg_q,
  output logic              init_q
);
  cfg_t cfg_d;
  logic drv_ok;
  logic changed;
  logic unused_bits;

  assign unused_bits = ^{wdata[31:24], wdata[17:16], wdata[13:12], wdata[8:7], wdata[3]};

  always_comb begin
    cfg_d   = cfg_q;
    drv_ok  = wr_en && cfg_q.boot && !wdata[B_BOOT];
    if (wr_en) begin
      cfg_d.boot  = wdata[B_BOOT];
      cfg_d.spare = wdata[SPARE_LO+3:SPARE_LO];
      cfg_d.tunl  = wdata[B_TUNL];
      cfg_d.bus16 = wdata[B_BUS16];
      cfg_d.cl    = wdata[CL_LO+CODE_W-1:CL_LO];
      cfg_d.bank  = wdata[BANK_LO+CODE_W-1:BANK_LO];
      cfg_d.page  = wdata[PAGE_LO+CODE_W-1:PAGE_LO];
    end
    if (drv_ok) cfg_d.drive = wdata[B_DRIVE];
    changed = wr_en && ((cfg_d.drive != cfg_q.drive) || (cfg_d.cl != cfg_q.cl) ||
                        (cfg_d.bank != cfg_q.bank) || (cfg_d.page != cfg_q.page));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      init_q <= 1'b0;
    end else begin
      if (wr_en) cfg_q <= cfg_d;
      init_q <= changed;
    end
  end

  // R4 / R5: drive moves only after a clearing write while boot-unlock was set
  assert_drive_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.drive != $past(cfg_q.drive)) |-> $past(wr_en && cfg_q.boot && !wdata[B_BOOT]));

  // R8: a pulse always follows a write
  assert_init_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |-> $past(wr_en));

  // R9: a pulse always comes with a changed trigger field
  assert_init_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |-> ((cfg_q.drive != $past(cfg_q.drive)) || (cfg_q.cl != $past(cfg_q.cl)) ||
                (cfg_q.bank != $past(cfg_q.bank)) || (cfg_q.page != $past(cfg_q.page))));
endmodule

// File: rtl/dram_tim_word.sv
module dram_tim_word #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         unlocked,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic         load;
  logic [W-1:0] d;

  always_comb begin
    load = wr_en && unlocked;
    d    = load ? wdata : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  // R6: stored value changes only through an unlocked write
  assert_tim_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (q != $past(q)) |-> $past(wr_en && unlocked));
endmodule

// File: rtl/dram_rd_mux.sv
module dram_rd_mux #(
  parameter int ADDR_W   = 4,
  parameter int NUM_TIM  = 2,
  parameter int CFG_ADDR = 0,
  parameter int TIM_BASE = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [31:0]               cfg_word,
  input  logic [NUM_TIM*32-1:0]     tim_flat,
  output logic [31:0]               rdata
);
  logic mapped;

  always_comb begin
    rdata  = '0;
    mapped = 1'b0;
    if (addr == ADDR_W'(CFG_ADDR)) begin
      rdata  = cfg_word;
      mapped = 1'b1;
    end
    for (int i = 0; i < NUM_TIM; i++) begin
      if (addr == ADDR_W'(TIM_BASE + i)) begin
        rdata  = tim_flat[32*i +: 32];
        mapped = 1'b1;
      end
    end
  end

  // R2: constant bits of the configuration word as seen on the bus
  assert_ro_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(CFG_ADDR)) |-> (rdata[31:24] == 8'h0 && rdata[17:16] == 2'b11 &&
                                     rdata[13:12] == 2'b00 && rdata[8:7] == 2'b00 && !rdata[3]));

  // R10: unmapped reads are zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (rdata == 32'h0));
endmodule

// File: rtl/dram_cfg_regs.sv
module dram_cfg_regs
  import dram_cfg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NUM_TIM  = 2,
  parameter int CFG_ADDR = 0,
  parameter int TIM_BASE = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_we,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic                   init_start,
  output logic                   drive_weak,
  output logic                   bus16_sel,
  output logic [CODE_W-1:0]      cas_lat,
  output logic [CODE_W-1:0]      bank_code,
  output logic [CODE_W-1:0]      page_code,
  output logic [NUM_TIM*DATA_W-1:0] tim_flat
);
  localparam int TIM_W = NUM_TIM * DATA_W;

  logic rst_s_n;
  cfg_t cfg_q;
  logic cfg_we;

  dram_rst_sync u_rst (.clk(clk), .rst_ni(rst_n), .rst_no(rst_s_n));

  assign cfg_we = bus_we && (bus_addr == ADDR_W'(CFG_ADDR));

  dram_cfg_word u_cfg (
    .clk(clk), .rst_n(rst_s_n), .wr_en(cfg_we), .wdata(bus_wdata),
    .cfg_q(cfg_q), .init_q(init_start)
  );

  for (genvar i = 0; i < NUM_TIM; i++) begin : g_tim
    logic tim_we;
    assign tim_we = bus_we && (bus_addr == ADDR_W'(TIM_BASE + i));
    dram_tim_word #(.W(DATA_W)) u_tim (
      .clk(clk), .rst_n(rst_s_n), .wr_en(tim_we), .unlocked(cfg_q.tunl),
      .wdata(bus_wdata), .q(tim_flat[DATA_W*i +: DATA_W])
    );
  end

  dram_rd_mux #(.ADDR_W(ADDR_W), .NUM_TIM(NUM_TIM), .CFG_ADDR(CFG_ADDR), .TIM_BASE(TIM_BASE)) u_mux (
    .clk(clk), .rst_n(rst_s_n), .addr(bus_addr), .cfg_word(cfg_word(cfg_q)),
    .tim_flat(tim_flat[TIM_W-1:0]), .rdata(bus_rdata)
  );

  assign drive_weak = cfg_q.drive;
  assign bus16_sel  = cfg_q.bus16;
  assign cas_lat    = cfg_q.cl;
  assign bank_code  = cfg_q.bank;
  assign page_code  = cfg_q.page;
endmodule

// File: tb/dram_cfg_regs_test.sv
module dram_cfg_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        init_start, drive_weak, bus16_sel;
  logic [2:0]  cas_lat, bank_code, page_code;
  logic [63:0] tim_flat;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dram_cfg_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .init_start(init_start), .drive_weak(drive_weak),
    .bus16_sel(bus16_sel), .cas_lat(cas_lat), .bank_code(bank_code),
    .page_code(page_code), .tim_flat(tim_flat)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rexp;
    logic        iexp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{4'd6,  4'd1, 32'h1234_5678, 32'h0000_0000, 1'b0}, // R6 locked timing write
    '{4'd9,  4'd0, 32'h0017_8A20, 32'h0017_8A20, 1'b0}, // R9 set timing-unlock only
    '{4'd7,  4'd1, 32'h1234_5678, 32'h1234_5678, 1'b0}, // R7 unlocked timing 0
    '{4'd11, 4'd2, 32'hCAFE_F00D, 32'hCAFE_F00D, 1'b0}, // R11 timing 1 at address 2
    '{4'd5,  4'd0, 32'h0013_8A20, 32'h0017_8A20, 1'b0}, // R5 drive change without unlock
    '{4'd9,  4'd0, 32'h0097_8A20, 32'h0097_8A20, 1'b0}, // R9 boot-unlock step one
    '{4'd4,  4'd0, 32'h0013_8A20, 32'h0013_8A20, 1'b1}, // R4 step two sets normal drive
    '{4'd3,  4'd0, 32'h0013_4632, 32'h0013_4632, 1'b1}, // R3 new codes, relock timing
    '{4'd6,  4'd1, 32'hFFFF_FFFF, 32'h1234_5678, 1'b0}, // R6 relocked timing write
    '{4'd2,  4'd0, 32'hFF0C_7B8F, 32'h000B_4A07, 1'b1}, // R2 constant bits
    '{4'd9,  4'd0, 32'hFF0C_7B8F, 32'h000B_4A07, 1'b0}, // R9 same values repeated
    '{4'd10, 4'd7, 32'hDEAD_BEEF, 32'h0000_0000, 1'b0}  // R10 unmapped
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    bus_addr = a;
    #1;
  endtask

  task automatic check_reset_state();
    rd(4'd0); chk("R1 cfg word", bus_rdata, 32'h0017_0A20);
    rd(4'd1); chk("R1 timing 0", bus_rdata, 0);
    rd(4'd2); chk("R1 timing 1", bus_rdata, 0);
    chk("R1 init_start", init_start, 0);
    chk("R1 decoded", {drive_weak, bus16_sel, cas_lat, bank_code, page_code},
        {1'b1, 1'b0, 3'd5, 3'd2, 3'd0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state();

    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i].addr, VEC[i].wdata);
      if (init_start !== VEC[i].iexp) begin
        checks++; failures++;
        $display("FAIL R%0d vec %0d init_start actual=%0b expected=%0b",
                 VEC[i].req, i, init_start, VEC[i].iexp);
      end else checks++;
      rd(VEC[i].addr);
      if (bus_rdata !== VEC[i].rexp) begin
        checks++; failures++;
        $display("FAIL R%0d vec %0d rdata actual=0x%0h expected=0x%0h",
                 VEC[i].req, i, bus_rdata, VEC[i].rexp);
      end else checks++;
    end

    chk("R3 decoded fields", {drive_weak, bus16_sel, cas_lat, bank_code, page_code},
        {1'b0, 1'b1, 3'd5, 3'd0, 3'd7});
    chk("R7 timing outputs", tim_flat, 64'hCAFE_F00D_1234_5678);
    rd(4'd1); chk("R7 locked readback", bus_rdata, 32'h1234_5678);

    // R5: write with boot-unlock still set keeps drive
    bus_write(4'd0, 32'h008B_4A07);
    chk("R9 unlock no pulse", init_start, 0);
    bus_write(4'd0, 32'h008F_4A07);
    chk("R5 init_start", init_start, 0);
    rd(4'd0); chk("R5 drive kept", bus_rdata, 32'h008B_4A07);
    chk("R5 drive_weak", drive_weak, 0);
    // R4: clearing write carries weak drive
    bus_write(4'd0, 32'h000F_4A07);
    chk("R8 pulse", init_start, 1);
    chk("R4 drive_weak", drive_weak, 1);
    rd(4'd0); chk("R4 cfg word", bus_rdata, 32'h000F_4A07);
    @(negedge clk);
    chk("R8 pulse width", init_start, 0);

    // R1: asynchronous reset mid-run
    rst_n = 1'b0;
    #2;
    check_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule